// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Tags

This block buffers received serial characters between a UART deserializer and the host. Each accepted character is stored with its own break, framing and parity error flags. The error flags presented to the host always belong to the oldest stored character, which is the one the next pop will return. The host therefore reads the flags first and then pops the data, and each error stays paired with the character that carried it.

The block reports how many characters it holds. It raises an interrupt request when that count reaches a threshold. The threshold is either picked from four fixed values or set through a programmable field, and a nonzero programmable value takes precedence. After reset the queue is in its disabled mode: it holds a single character and the threshold is one. A flush command empties the queue over two clock cycles. A character that arrives while the queue is full is dropped and a sticky overrun flag is set.

Top module: `rx_err_fifo`

## Requirements
- R1: With `fifoEn` high the queue holds up to 64 characters. Popping returns them in arrival order, and each pop returns the 8 data bits written with that character.
- R2: `headBreak`, `headFrame` and `headParity` show the flags stored with the oldest held character. They are 0 when the queue is empty.
- R3: `level` equals the number of characters held, from 0 to 64. A write and a pop in the same cycle leave it unchanged.
- R4: After reset `level` is 0 and `irq`, `overrun` and `flushBusy` are 0. With `fifoEn` low the capacity is one character and the trigger threshold is one.
- R5: With `fifoEn` high and `trigProg` zero, `trigSel` codes 0, 1, 2 and 3 give thresholds of 8, 16, 56 and 60 characters.
- R6: With `fifoEn` high and `trigProg` nonzero, the threshold is `trigProg` times 4, whatever `trigSel` holds.
- R7: `irq` is high exactly when `level` is greater than or equal to the active threshold. It goes low as soon as `level` drops below it.
- R8: A write while `level` equals the capacity is dropped and sets `overrun`. `overrun` stays high until a cycle with `statusRd` high clears it.
- R9: A pop while the queue is empty leaves `level` at 0 and leaves `rdData` at its previous value.
- R10: `flushReq` empties the queue: `level` is 0 from the next cycle. `flushBusy` is then high for two cycles, and writes and pops during that time have no effect.
- R11: `rdData` is registered. It takes the popped character on the clock edge that accepts the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoEn | input | 1 | 1: 64-deep queue with selectable thresholds; 0: single-character mode |
| trigSel | input | 2 | Fixed threshold select code |
| trigProg | input | 4 | Programmable threshold in units of 4; 0 selects the fixed set |
| wrValid | input | 1 | Deserializer offers a character this cycle |
| wrData | input | 8 | Received character |
| wrBreak | input | 1 | Break flag for the offered character |
| wrFrame | input | 1 | Framing error flag for the offered character |
| wrParity | input | 1 | Parity error flag for the offered character |
| popReq | input | 1 | Host removes the oldest character |
| rdData | output | 8 | Last popped character |
| headBreak | output | 1 | Break flag of the oldest held character |
| headFrame | output | 1 | Framing flag of the oldest held character |
| headParity | output | 1 | Parity flag of the oldest held character |
| level | output | 7 | Number of held characters |
| irq | output | 1 | Threshold interrupt request |
| statusRd | input | 1 | Host status read; clears the overrun flag |
| overrun | output | 1 | Sticky flag for a dropped character |
| flushReq | input | 1 | Starts a queue flush |
| flushBusy | output | 1 | Flush in progress |

## Verification
The bench fills the queue to exactly 64 characters and offers a 65th. If the full test were off by one, the 65th character would either corrupt the oldest entry or be lost without setting `overrun`. At levels just below and at each threshold, the bench sweeps every select code and several programmable values. A mistake in threshold precedence or in the `>=` comparison shows up there as an early or late `irq`. Characters carry distinct flag patterns, so flags read from the wrong slot (the tail, or the entry after the head) disagree with the scoreboard. The bench also pops an empty queue, offers writes during a flush, and writes and pops in the same cycle; a design that got these wrong would drift its count or change `rdData`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int DATA_W = 8;

  // One stored character with its error tags
  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  // Strobes from the control to the storage
  typedef struct packed {
    logic doWrite;
    logic doPop;
    logic doClear;
    logic headValid;
  } rxStrobe_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  rxEntry_t          wrEntry,
  output rxEntry_t          headEntry,
  output logic [DATA_W-1:0] rdData
);

  localparam int AW = $clog2(DEPTH);

  rxEntry_t        mem [DEPTH];
  logic [AW-1:0]   headPtr;
  logic [AW-1:0]   tailPtr;

  // Storage array holds no reset; validity is tracked by the control level
  always_ff @(posedge clk) begin
    if (strb.doWrite) begin
      mem[tailPtr] <= wrEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      rdData  <= '0;
    end else if (strb.doClear) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strb.doWrite) begin
        tailPtr <= (tailPtr == AW'(DEPTH-1)) ? '0 : tailPtr + 1'b1;
      end
      if (strb.doPop) begin
        rdData  <= mem[headPtr].data;
        headPtr <= (headPtr == AW'(DEPTH-1)) ? '0 : headPtr + 1'b1;
      end
    end
  end

  // Head view is masked while nothing is held
  always_comb begin
    headEntry = '0;
    if (strb.headValid) begin
      headEntry = mem[headPtr];
    end
  end

  // R10: the control never clears and stores in the same cycle
  p_clear_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.doClear |-> !strb.doWrite && !strb.doPop);

  // R9: a pop is only issued against a held character
  p_pop_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPop |-> strb.headValid);

  // R11: rdData moves only on an accepted pop
  p_rddata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doPop |=> $stable(rdData));

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int SEL_W  = 2,
  parameter int PROG_W = 4,
  parameter int PROG_STEP = 4,
  parameter int FLUSH_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic [SEL_W-1:0]  trigSel,
  input  logic [PROG_W-1:0] trigProg,
  input  logic              wrValid,
  input  logic              popReq,
  input  logic              statusRd,
  input  logic              flushReq,
  output rxStrobe_t         strb,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic              irq,
  output logic              overrun,
  output logic              flushBusy
);

  localparam int LW = $clog2(DEPTH+1);
  localparam int FW = $clog2(FLUSH_CYC+1);
  localparam logic [LW-1:0] FULL_DEEP = LW'(DEPTH);
  localparam logic [LW-1:0] FULL_ONE  = LW'(1);

  logic [FW-1:0] flushCnt;
  logic [LW-1:0] capacity;
  logic [LW-1:0] threshold;
  logic [LW-1:0] selThr;
  logic          blocked;
  logic          isFull;
  logic          isEmpty;
  logic          acceptPop;
  logic          acceptWrite;
  logic          dropWrite;

  assign blocked   = flushReq || flushBusy;
  assign capacity  = fifoEn ? FULL_DEEP : FULL_ONE;
  assign isFull    = (level >= capacity);
  assign isEmpty   = (level == '0);

  assign acceptPop   = popReq && !isEmpty && !blocked;
  assign acceptWrite = wrValid && !isFull && !blocked;
  assign dropWrite   = wrValid && isFull && !blocked;

  // Fixed threshold set: two low marks, two marks near the top
  always_comb begin
    unique case (trigSel)
      2'd0:    selThr = LW'(8);
      2'd1:    selThr = LW'(16);
      2'd2:    selThr = LW'(DEPTH-8);
      default: selThr = LW'(DEPTH-4);
    endcase
  end

  always_comb begin
    if (!fifoEn) begin
      threshold = LW'(1);
    end else if (trigProg != '0) begin
      threshold = LW'(trigProg) * LW'(PROG_STEP);
    end else begin
      threshold = selThr;
    end
  end

  assign irq = (level >= threshold);

  always_comb begin
    strb.doWrite   = acceptWrite;
    strb.doPop     = acceptPop;
    strb.doClear   = flushReq && !flushBusy;
    strb.headValid = !isEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= '0;
    end else if (strb.doClear) begin
      level <= '0;
    end else begin
      case ({acceptWrite, acceptPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushCnt  <= '0;
      flushBusy <= 1'b0;
    end else if (flushReq && !flushBusy) begin
      flushCnt  <= FW'(FLUSH_CYC - 1);
      flushBusy <= 1'b1;
    end else if (flushBusy) begin
      if (flushCnt == '0) begin
        flushBusy <= 1'b0;
      end else begin
        flushCnt <= flushCnt - 1'b1;
      end
    end
  end

  // Sticky overrun: a drop in the same cycle as a status read wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
    end else if (dropWrite) begin
      overrun <= 1'b1;
    end else if (statusRd) begin
      overrun <= 1'b0;
    end
  end

  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_DEEP);

  p_irq_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !irq);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !statusRd |=> overrun);

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    popReq && isEmpty && !wrValid |=> isEmpty);

  p_flush_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && !flushBusy |=> flushBusy && isEmpty);

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEn,
  input  logic [1:0] trigSel,
  input  logic [3:0] trigProg,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrBreak,
  input  logic       wrFrame,
  input  logic       wrParity,
  input  logic       popReq,
  output logic [7:0] rdData,
  output logic       headBreak,
  output logic       headFrame,
  output logic       headParity,
  output logic [6:0] level,
  output logic       irq,
  input  logic       statusRd,
  output logic       overrun,
  input  logic       flushReq,
  output logic       flushBusy
);

  rxStrobe_t strb;
  rxEntry_t  wrEntry;
  rxEntry_t  headEntry;

  always_comb begin
    wrEntry.brk  = wrBreak;
    wrEntry.frm  = wrFrame;
    wrEntry.par  = wrParity;
    wrEntry.data = wrData;
  end

  rxq_ctrl #(
    .DEPTH(DEPTH), .SEL_W(2), .PROG_W(4), .PROG_STEP(4), .FLUSH_CYC(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .trigSel(trigSel),
    .trigProg(trigProg), .wrValid(wrValid), .popReq(popReq),
    .statusRd(statusRd), .flushReq(flushReq), .strb(strb),
    .level(level), .irq(irq), .overrun(overrun), .flushBusy(flushBusy)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEntry(wrEntry),
    .headEntry(headEntry), .rdData(rdData)
  );

  assign headBreak  = headEntry.brk;
  assign headFrame  = headEntry.frm;
  assign headParity = headEntry.par;

  // R2: an empty queue shows no error tags
  p_head_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    level == '0 |-> !(headBreak || headFrame || headParity));

endmodule

// File: tb/rx_err_fifo_bench.sv
module rx_err_fifo_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b0;
  logic [1:0] trigSel = '0;
  logic [3:0] trigProg = '0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrBreak = 1'b0, wrFrame = 1'b0, wrParity = 1'b0;
  logic       popReq = 1'b0;
  logic [7:0] rdData;
  logic       headBreak, headFrame, headParity;
  logic [6:0] level;
  logic       irq;
  logic       statusRd = 1'b0;
  logic       overrun;
  logic       flushReq = 1'b0;
  logic       flushBusy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [10:0] scoreQ[$];   // {brk, frm, par, data}
  logic [7:0]  lastRd = '0;

  always #4 clk = ~clk;

  rx_err_fifo u_rx_err_fifo (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .trigSel(trigSel),
    .trigProg(trigProg), .wrValid(wrValid), .wrData(wrData),
    .wrBreak(wrBreak), .wrFrame(wrFrame), .wrParity(wrParity),
    .popReq(popReq), .rdData(rdData), .headBreak(headBreak),
    .headFrame(headFrame), .headParity(headParity), .level(level),
    .irq(irq), .statusRd(statusRd), .overrun(overrun),
    .flushReq(flushReq), .flushBusy(flushBusy)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expThr(bit en, int sel, int prog);
    if (!en) return 1;
    if (prog != 0) return prog * 4;
    case (sel)
      0: return 8;
      1: return 16;
      2: return 56;
      default: return 60;
    endcase
  endfunction

  // Driver: offers one character, scoreboards it when it should be taken
  task automatic pushChar(logic [7:0] d, logic [2:0] f, bit expTake);
    @(negedge clk);
    wrValid = 1'b1; wrData = d;
    {wrBreak, wrFrame, wrParity} = f;
    @(negedge clk);
    wrValid = 1'b0;
    if (expTake) scoreQ.push_back({f, d});
  endtask

  // Monitor: compares head flags, then pops and compares the data
  task automatic popChar();
    logic [10:0] exp;
    if (scoreQ.size() == 0) return;
    exp = scoreQ[0];
    check("R2 head flags", {headBreak, headFrame, headParity}, exp[10:8]);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    check("R1 pop data", rdData, exp[7:0]);
    void'(scoreQ.pop_front());
    lastRd = exp[7:0];
    check("R3 level after pop", level, scoreQ.size());
  endtask

  task automatic sweepIrq(string tag);
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s); trigProg = '0; #1;
      check({tag, " R5 sel irq"}, irq, (level >= expThr(1, s, 0)));
    end
    for (int p = 1; p < 16; p += 3) begin
      trigProg = 4'(p); trigSel = 2'd3; #1;
      check({tag, " R6 prog irq"}, irq, (level >= expThr(1, 3, p)));
    end
    trigProg = '0; trigSel = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset state
    check("R4 level", level, 0);
    check("R4 irq", irq, 0);
    check("R4 overrun", overrun, 0);
    check("R4 flushBusy", flushBusy, 0);
    check("R2 empty flags", {headBreak, headFrame, headParity}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: single-character mode, threshold one
    pushChar(8'hA5, 3'b101, 1);
    check("R4 level one", level, 1);
    check("R4 irq at one", irq, 1);
    pushChar(8'h3C, 3'b010, 0);
    check("R8 overrun set", overrun, 1);
    check("R8 level held", level, 1);
    @(negedge clk);
    check("R8 overrun sticky", overrun, 1);
    statusRd = 1'b1; @(negedge clk); statusRd = 1'b0;
    check("R8 overrun cleared", overrun, 0);
    popChar();
    check("R7 irq drops", irq, 0);

    // R9: pop on empty
    popReq = 1'b1; @(negedge clk); popReq = 1'b0;
    check("R9 rdData held", rdData, lastRd);
    check("R9 level zero", level, 0);

    // Deep mode, fill step by step and sweep thresholds
    fifoEn = 1'b1;
    for (int i = 0; i < 64; i++) begin
      pushChar(8'(i * 7 + 3), 3'(i % 8), 1);
      if (i + 1 inside {7, 8, 15, 16, 55, 56, 59, 60, 64}) begin
        check("R3 level fill", level, i + 1);
        sweepIrq("fill");
      end
    end
    // R8: write into a full deep queue
    pushChar(8'hEE, 3'b111, 0);
    check("R8 full overrun", overrun, 1);
    check("R8 full level", level, 64);
    statusRd = 1'b1; @(negedge clk); statusRd = 1'b0;
    // R1: drain in order with flags
    for (int i = 0; i < 64; i++) begin
      popChar();
      if (level == 59 || level == 55 || level == 7) sweepIrq("drain");
    end
    check("R7 irq empty", irq, 0);

    // R3: write and pop in the same cycle
    pushChar(8'h11, 3'b001, 1);
    pushChar(8'h22, 3'b100, 1);
    @(negedge clk);
    wrValid = 1'b1; wrData = 8'h33; {wrBreak, wrFrame, wrParity} = 3'b010;
    popReq = 1'b1;
    @(negedge clk);
    wrValid = 1'b0; popReq = 1'b0;
    check("R11 rdData simultaneous", rdData, 8'h11);
    check("R3 level simultaneous", level, 2);
    void'(scoreQ.pop_front());
    scoreQ.push_back({3'b010, 8'h33});
    popChar();
    popChar();

    // R10: flush
    for (int i = 0; i < 5; i++) pushChar(8'(8'h40 + i), 3'b000, 1);
    @(negedge clk);
    flushReq = 1'b1; @(negedge clk); flushReq = 1'b0;
    check("R10 busy", flushBusy, 1);
    check("R10 level cleared", level, 0);
    scoreQ.delete();
    wrValid = 1'b1; wrData = 8'h77; popReq = 1'b1;
    @(negedge clk);
    wrValid = 1'b0; popReq = 1'b0;
    check("R10 busy second cycle", flushBusy, 1);
    check("R10 write ignored", level, 0);
    check("R10 pop ignored", rdData, lastRd);
    @(negedge clk);
    check("R10 busy ends", flushBusy, 0);
    check("R10 level stays", level, 0);
    pushChar(8'h5A, 3'b011, 1);
    check("R10 accepts after flush", level, 1);
    popChar();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule